// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the general-purpose registers of a 32-bit core whose register view changes with the processor mode. Software sees fifteen logical registers, numbered 0 to 14. A 5-bit mode code chooses which physical copy each logical number reaches. The low eight registers are common to all modes. The fast-interrupt mode has its own copies of registers 8 to 14. The interrupt, supervisor, abort and undefined modes each have their own registers 13 and 14. The system mode reaches the user copies.

Each exception mode also has a saved-status word. A dedicated port reads and writes the saved-status word of the mode currently presented. Two read ports and one write port use logical register numbers. Reads are combinational. Writes land on the rising clock edge.

The core drives `mode_i` from its status register every cycle. All ports are plain control and data pins with no handshake. An access is taken in the cycle it is presented, so no back-pressure exists. The error pin flags an unknown mode code, or an attempt to reach a saved-status word from a mode that has none.

Top module: `regbank_top`

## Requirements
- R1: Logical registers 0 to 7 read and write the same physical word in every valid mode.
- R2: In fast-interrupt mode (code 0x11), registers 8 to 14 reach seven private words. These words are not visible from any other mode.
- R3: Interrupt (0x12), supervisor (0x13), abort (0x17) and undefined (0x1B) modes each have private registers 13 and 14. Their registers 8 to 12 are the user words.
- R4: System mode (0x1F) reaches exactly the same words as user mode (0x10) for all of registers 0 to 14.
- R5: Each of the five exception modes (0x11, 0x12, 0x13, 0x17, 0x1B) has its own saved-status word. `sv_rd_data` shows the word of the present mode. A write with `sv_wr_en` takes effect at the next rising edge.
- R6: `mode_err` is high when `mode_i` is not one of the seven listed codes. It is also high in user or system mode while `sv_rd_req` or `sv_wr_en` is high. In user or system mode `sv_rd_data` reads zero and saved-status writes are dropped.
- R7: Read data follows the addresses and the present mode combinationally. A write with `wr_en` is visible on either read port from the cycle after the rising edge that took it.
- R8: Under an unknown mode code, register and saved-status writes are suppressed and all read ports return zero.
- R9: An active-low asynchronous reset clears every register word and every saved-status word to zero.
- R10: Logical register number 15 reads as zero on both read ports, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 5 | Present processor mode code |
| rd_a_idx | input | 4 | Read port A logical register number |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B logical register number |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Write logical register number |
| wr_data | input | 32 | Write data |
| sv_rd_req | input | 1 | Saved-status read request, used for error reporting |
| sv_rd_data | output | 32 | Saved-status word of the present mode |
| sv_wr_en | input | 1 | Saved-status write enable |
| sv_wr_data | input | 32 | Saved-status write data |
| mode_err | output | 1 | Unknown mode, or saved-status access with none present |

## Verification
A wrong bank mapping appears as a value written in one mode that shows up in another mode. The bench makes this visible on the read ports in the first cycle after the mode changes. A wrong write decode, or a write that is not suppressed, corrupts a word silently. That fault stays hidden until some later read of that word in the affected mode. For this reason the bench sweeps every register in every mode after each directed phase, and it compares all outputs against the model on every cycle of a long random run. Error-flag faults need no waiting, because `mode_err` is combinational and is compared in the same cycle as its cause.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  // Mode codes presented on mode_i.
  localparam logic [4:0] MODE_USR = 5'h10;
  localparam logic [4:0] MODE_FIQ = 5'h11;
  localparam logic [4:0] MODE_IRQ = 5'h12;
  localparam logic [4:0] MODE_SVC = 5'h13;
  localparam logic [4:0] MODE_ABT = 5'h17;
  localparam logic [4:0] MODE_UND = 5'h1B;
  localparam logic [4:0] MODE_SYS = 5'h1F;

  // Register view selected by a mode. The order is fixed: the four lowest
  // views equal the mode code with its top bit cleared.
  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

endpackage

// File: rtl/regbank_mode_dec.sv
module regbank_mode_dec
  import regbank_pkg::*;
(
  input  logic [4:0] mode_i,
  output bank_e      bank_o,
  output logic       valid_o,
  output logic       has_sv_o,
  output logic [2:0] sv_idx_o
);

  always_comb begin
    bank_o   = BK_USR;
    valid_o  = 1'b1;
    has_sv_o = 1'b1;
    case (mode_i)
      MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC:
        bank_o = bank_e'({1'b0, mode_i[1:0]});
      MODE_ABT: bank_o = BK_ABT;
      MODE_UND: bank_o = BK_UND;
      MODE_SYS: bank_o = BK_USR;
      default: begin
        valid_o  = 1'b0;
        has_sv_o = 1'b0;
      end
    endcase
    if (bank_o == BK_USR) has_sv_o = 1'b0;
  end

  // Saved-status words are numbered from the fast-interrupt view upward.
  assign sv_idx_o = 3'(bank_o) - 3'd1;

endmodule

// File: rtl/regbank_slot_map.sv
module regbank_slot_map
  import regbank_pkg::*;
#(
  parameter int NUM_LOG = 15,
  parameter int FIQ_LO  = 8,
  parameter int BANK_LO = 13,
  parameter int IDX_W   = 4,
  parameter int SLOT_W  = 5
) (
  input  bank_e              bank_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [SLOT_W-1:0]  slot_o,
  output logic               hit_o
);

  localparam int FIQ_CNT   = NUM_LOG - FIQ_LO;
  localparam int PAIR_CNT  = NUM_LOG - BANK_LO;
  localparam int FIQ_BASE  = NUM_LOG;
  localparam int PAIR_BASE = FIQ_BASE + FIQ_CNT;

  int s;

  always_comb begin
    hit_o = (int'(idx_i) < NUM_LOG);
    s     = int'(idx_i);
    if (bank_i == BK_FIQ && int'(idx_i) >= FIQ_LO) begin
      s = FIQ_BASE + int'(idx_i) - FIQ_LO;
    end else if (bank_i != BK_USR && bank_i != BK_FIQ && int'(idx_i) >= BANK_LO) begin
      s = PAIR_BASE + (int'(bank_i) - 2) * PAIR_CNT + int'(idx_i) - BANK_LO;
    end
    slot_o = s[SLOT_W-1:0];
  end

endmodule

// File: rtl/regbank_store.sv
module regbank_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 30,
  parameter int NRD    = 2,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we_i,
  input  logic [AW-1:0]              wa_i,
  input  logic [DATA_W-1:0]          wd_i,
  input  logic [NRD-1:0][AW-1:0]     ra_i,
  output logic [NRD-1:0][DATA_W-1:0] rd_o
);

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           mem[e] <= '0;
      else if (we_i && wa_i == AW'(e))      mem[e] <= wd_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_o[p] = (int'(ra_i[p]) < DEPTH) ? mem[ra_i[p]] : '0;
  end

endmodule

// File: rtl/regbank_top.sv
module regbank_top
  import regbank_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_LOG = 15,
  parameter int FIQ_LO  = 8,
  parameter int BANK_LO = 13,
  localparam int IDX_W  = $clog2(NUM_LOG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        mode_i,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sv_rd_req,
  output logic [DATA_W-1:0] sv_rd_data,
  input  logic              sv_wr_en,
  input  logic [DATA_W-1:0] sv_wr_data,
  output logic              mode_err
);

  localparam int FIQ_CNT  = NUM_LOG - FIQ_LO;
  localparam int PAIR_CNT = NUM_LOG - BANK_LO;
  localparam int N_SLOTS  = NUM_LOG + FIQ_CNT + 4 * PAIR_CNT;
  localparam int SLOT_W   = $clog2(N_SLOTS);
  localparam int N_SV     = 5;
  localparam int SV_W     = $clog2(N_SV);
  localparam int N_PORT   = 3;   // 0: read A, 1: read B, 2: write

  bank_e       bank;
  logic        mode_ok;
  logic        has_sv;
  logic [2:0]  sv_idx;

  regbank_mode_dec u_dec (
    .mode_i   (mode_i),
    .bank_o   (bank),
    .valid_o  (mode_ok),
    .has_sv_o (has_sv),
    .sv_idx_o (sv_idx)
  );

  logic [N_PORT-1:0][IDX_W-1:0]  log_idx;
  logic [N_PORT-1:0][SLOT_W-1:0] phys;
  logic [N_PORT-1:0]             hit;

  assign log_idx = {wr_idx, rd_b_idx, rd_a_idx};

  for (genvar p = 0; p < N_PORT; p++) begin : g_map
    regbank_slot_map #(
      .NUM_LOG (NUM_LOG),
      .FIQ_LO  (FIQ_LO),
      .BANK_LO (BANK_LO),
      .IDX_W   (IDX_W),
      .SLOT_W  (SLOT_W)
    ) u_map (
      .bank_i (bank),
      .idx_i  (log_idx[p]),
      .slot_o (phys[p]),
      .hit_o  (hit[p])
    );
  end

  logic [1:0][DATA_W-1:0] gp_raw;
  logic                   gp_we;

  assign gp_we = wr_en && mode_ok && hit[2];

  regbank_store #(
    .DATA_W (DATA_W),
    .DEPTH  (N_SLOTS),
    .NRD    (2)
  ) u_gp (
    .clk   (clk),
    .rst_n (rst_n),
    .we_i  (gp_we),
    .wa_i  (phys[2]),
    .wd_i  (wr_data),
    .ra_i  (phys[1:0]),
    .rd_o  (gp_raw)
  );

  assign rd_a_data = (mode_ok && hit[0]) ? gp_raw[0] : '0;
  assign rd_b_data = (mode_ok && hit[1]) ? gp_raw[1] : '0;

  logic [0:0][DATA_W-1:0] sv_raw;
  logic [0:0][SV_W-1:0]   sv_ra;
  logic                   sv_we;

  assign sv_ra[0] = sv_idx[SV_W-1:0];
  assign sv_we    = sv_wr_en && has_sv;

  regbank_store #(
    .DATA_W (DATA_W),
    .DEPTH  (N_SV),
    .NRD    (1)
  ) u_sv (
    .clk   (clk),
    .rst_n (rst_n),
    .we_i  (sv_we),
    .wa_i  (sv_idx[SV_W-1:0]),
    .wd_i  (sv_wr_data),
    .ra_i  (sv_ra),
    .rd_o  (sv_raw)
  );

  assign sv_rd_data = has_sv ? sv_raw[0] : '0;
  assign mode_err   = !mode_ok || (!has_sv && (sv_rd_req || sv_wr_en));

endmodule

// File: rtl/regbank_chk.sv
module regbank_chk #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        mode_i,
  input logic [IDX_W-1:0]  rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [IDX_W-1:0]  rd_b_idx,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              sv_rd_req,
  input logic [DATA_W-1:0] sv_rd_data,
  input logic              sv_wr_en,
  input logic [DATA_W-1:0] sv_wr_data,
  input logic              mode_err
);

  logic known, plain;
  assign known = (mode_i == 5'h10) || (mode_i == 5'h11) || (mode_i == 5'h12) ||
                 (mode_i == 5'h13) || (mode_i == 5'h17) || (mode_i == 5'h1B) ||
                 (mode_i == 5'h1F);
  assign plain = (mode_i == 5'h10) || (mode_i == 5'h1F);

  // R1: a low register keeps its value across a mode change when nothing is written
  a_r1_low_regs_shared: assert property (@(posedge clk) disable iff (!rst_n)
    (known && rd_a_idx < 8 && !wr_en) |=>
      (!(known && $stable(rd_a_idx)) || rd_a_data == $past(rd_a_data)));

  // R6: saved-status access from user or system mode is flagged
  a_r6_sv_without_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (plain && (sv_rd_req || sv_wr_en)) |-> (mode_err && sv_rd_data == '0));

  // R7: a register write is visible on read port A in the next cycle
  a_r7_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && known && rd_a_idx < 15 && rd_a_idx == wr_idx) |=>
      (!($stable(mode_i) && $stable(rd_a_idx)) || rd_a_data == $past(wr_data)));

  // R5: a saved-status write is visible in the next cycle in the same mode
  a_r5_sv_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (sv_wr_en && known && !plain) |=>
      (!$stable(mode_i) || sv_rd_data == $past(sv_wr_data)));

  // R8: an unknown mode flags an error and reads zero
  a_r8_unknown_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !known |-> (mode_err && rd_a_data == '0 && rd_b_data == '0 && sv_rd_data == '0));

  // R10: register number 15 reads zero
  a_r10_idx15_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 4'd15) |-> (rd_a_data == '0));

  // R9: while reset is held all reads return zero
  a_r9_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (rd_a_data == '0 && rd_b_data == '0 && sv_rd_data == '0));

endmodule

bind regbank_top regbank_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_i     (mode_i),
  .rd_a_idx   (rd_a_idx),
  .rd_a_data  (rd_a_data),
  .rd_b_idx   (rd_b_idx),
  .rd_b_data  (rd_b_data),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .wr_data    (wr_data),
  .sv_rd_req  (sv_rd_req),
  .sv_rd_data (sv_rd_data),
  .sv_wr_en   (sv_wr_en),
  .sv_wr_data (sv_wr_data),
  .mode_err   (mode_err)
);

// File: tb/regbank_top_tb.sv
module regbank_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  mode_i = 5'h10;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, sv_rd_data;
  logic        wr_en = 1'b0, sv_rd_req = 1'b0, sv_wr_en = 1'b0;
  logic [31:0] wr_data = '0, sv_wr_data = '0;
  logic        mode_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  regbank_top u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .rd_a_idx   (rd_a_idx),
    .rd_a_data  (rd_a_data),
    .rd_b_idx   (rd_b_idx),
    .rd_b_data  (rd_b_data),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .sv_rd_req  (sv_rd_req),
    .sv_rd_data (sv_rd_data),
    .sv_wr_en   (sv_wr_en),
    .sv_wr_data (sv_wr_data),
    .mode_err   (mode_err)
  );

  // Behavioural reference: the user words, the fast-interrupt words,
  // one register pair per other exception view, one saved word per view.
  logic [31:0] m_usr  [15];
  logic [31:0] m_fiq  [7];
  logic [31:0] m_pair [4][2];
  logic [31:0] m_sv   [5];

  function automatic int view_of(input logic [4:0] m);
    case (m)
      5'h10, 5'h1F: return 0;
      5'h11: return 1;
      5'h12: return 2;
      5'h13: return 3;
      5'h17: return 4;
      5'h1B: return 5;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] mread(input logic [4:0] m, input int idx);
    int v = view_of(m);
    if (v < 0 || idx > 14) return '0;
    if (idx < 8) return m_usr[idx];
    if (v == 1) return m_fiq[idx-8];
    if (v >= 2 && idx >= 13) return m_pair[v-2][idx-13];
    return m_usr[idx];
  endfunction

  task automatic mwrite(input logic [4:0] m, input int idx, input logic [31:0] d);
    int v = view_of(m);
    if (v < 0 || idx > 14) return;
    if (idx < 8) m_usr[idx] = d;
    else if (v == 1) m_fiq[idx-8] = d;
    else if (v >= 2 && idx >= 13) m_pair[v-2][idx-13] = d;
    else m_usr[idx] = d;
  endtask

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Present inputs, compare all outputs, then let one clock edge pass.
  task automatic step(input string tag, input logic [4:0] m, input int ra, input int rb,
                      input bit we, input int wi, input logic [31:0] wd,
                      input bit srq, input bit swe, input logic [31:0] swd);
    int v;
    mode_i = m; rd_a_idx = 4'(ra); rd_b_idx = 4'(rb);
    wr_en = we; wr_idx = 4'(wi); wr_data = wd;
    sv_rd_req = srq; sv_wr_en = swe; sv_wr_data = swd;
    #1;
    v = view_of(m);
    check(tag, "rd_a", rd_a_data, mread(m, ra));
    check(tag, "rd_b", rd_b_data, mread(m, rb));
    check(tag, "sv_rd", sv_rd_data, (v >= 1) ? m_sv[v-1] : 32'h0);
    check(tag, "mode_err", {31'h0, mode_err},
          {31'h0, (v < 0) || (v == 0 && (srq || swe))});
    @(posedge clk);
    if (we) mwrite(m, wi, wd);
    if (swe && v >= 1) m_sv[v-1] = swd;
    @(negedge clk);
  endtask

  task automatic sweep(input string tag, input logic [4:0] m);
    for (int i = 0; i < 15; i++) step(tag, m, i, 14 - i, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam logic [4:0] MODES [7] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};
  localparam logic [4:0] BAD   [4] = '{5'h00, 5'h14, 5'h1A, 5'h16};

  initial begin
    for (int i = 0; i < 15; i++) m_usr[i] = '0;
    for (int i = 0; i < 7; i++) m_fiq[i] = '0;
    for (int i = 0; i < 4; i++) begin m_pair[i][0] = '0; m_pair[i][1] = '0; end
    for (int i = 0; i < 5; i++) m_sv[i] = '0;

    // R9: outputs during reset
    @(negedge clk);
    #1;
    check("R9", "rd_a in reset", rd_a_data, 32'h0);
    check("R9", "sv_rd in reset", sv_rd_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 7; k++) step("R9", MODES[k], 14, 3, 0, 0, 0, 0, 0, 0);

    // R1, R7: fill the user view, then sweep every view
    for (int i = 0; i < 15; i++) step("R7", 5'h10, i, i, 1, i, 32'h1000 + i, 0, 0, 0);
    sweep("R1", 5'h10);
    sweep("R2", 5'h11);
    sweep("R3", 5'h12);
    sweep("R3", 5'h17);
    sweep("R4", 5'h1F);

    // R2: private fast-interrupt copies; user view must be unchanged
    for (int i = 8; i < 15; i++) step("R2", 5'h11, i, 0, 1, i, 32'hF000 + i, 0, 0, 0);
    sweep("R2", 5'h11);
    sweep("R2", 5'h10);

    // R3: pairs of the four other exception views, plus a shared middle register
    for (int k = 2; k < 6; k++) begin
      step("R3", MODES[k], 13, 14, 1, 13, 32'hA000 + 32'(k), 0, 0, 0);
      step("R3", MODES[k], 13, 14, 1, 14, 32'hB000 + 32'(k), 0, 0, 0);
      step("R3", MODES[k], 10, 9, 1, 10, 32'hC000 + 32'(k), 0, 0, 0);
    end
    for (int k = 0; k < 7; k++) sweep("R3", MODES[k]);

    // R1: low register written from an exception view seen everywhere
    step("R1", 5'h1B, 2, 0, 1, 2, 32'h0BAD_0002, 0, 0, 0);
    for (int k = 0; k < 7; k++) step("R1", MODES[k], 2, 7, 0, 0, 0, 0, 0, 0);

    // R4: system mode writes land in the user words
    step("R4", 5'h1F, 13, 14, 1, 13, 32'h5555_0013, 0, 0, 0);
    step("R4", 5'h1F, 9, 14, 1, 9, 32'h5555_0009, 0, 0, 0);
    sweep("R4", 5'h10);

    // R5: one saved word per exception view
    for (int k = 1; k < 6; k++) step("R5", MODES[k], 0, 0, 0, 0, 0, 1, 1, 32'h5A00 + 32'(k));
    for (int k = 1; k < 6; k++) step("R5", MODES[k], 0, 0, 0, 0, 0, 1, 0, 0);

    // R6: no saved word in user or system mode
    step("R6", 5'h10, 0, 0, 0, 0, 0, 1, 0, 0);
    step("R6", 5'h1F, 0, 0, 0, 0, 0, 0, 1, 32'hDEAD_BEEF);
    step("R6", 5'h10, 0, 0, 0, 0, 0, 0, 1, 32'hDEAD_BEEF);
    for (int k = 1; k < 6; k++) step("R6", MODES[k], 0, 0, 0, 0, 0, 1, 0, 0);

    // R8: unknown modes suppress all writes and read zero
    for (int k = 0; k < 4; k++)
      step("R8", BAD[k], 3, 13, 1, 3, 32'hEEEE_0000 + 32'(k), 1, 1, 32'hEEEE_1111);
    for (int k = 0; k < 7; k++) step("R8", MODES[k], 3, 13, 0, 0, 0, 1, 0, 0);

    // R10: register number 15
    step("R10", 5'h13, 15, 15, 1, 15, 32'h1515_1515, 0, 0, 0);
    for (int k = 0; k < 7; k++) sweep("R10", MODES[k]);

    // R7: random traffic compared every cycle
    for (int n = 0; n < 600; n++) begin
      int pick = int'($urandom_range(0, 9));
      logic [4:0] m = (pick < 7) ? MODES[pick] : BAD[pick - 7];
      step("R7", m, int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
           $urandom_range(0, 1) == 1, int'($urandom_range(0, 15)), $urandom(),
           $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0, $urandom());
    end
    for (int k = 0; k < 7; k++) sweep("R7", MODES[k]);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule